// File: doc/BRIEF.md
# Virtualization Host-Mode Control Decoder

This block turns the state of a processor's hypervisor host mode into the three decisions the rest of the core needs each cycle. Its inputs are the current exception level, a host-extension enable bit, a host-trap bit, one routing bit for each physical interrupt class, a secure-monitor override for each class, and the class of the system register being accessed. Its outputs are the translation regime in force and the layout of that regime, the register bank the access reaches, and the exception level that takes each physical interrupt class.

When host-extension is enabled, a host kernel can run at the hypervisor level without changes. Its EL1-named register accesses are steered to the EL2 bank, and an alias encoding still reaches the real EL1 bank, so the hypervisor can swap guest state. The hypervisor regime gains an upper region and address space identifiers. When host-trap is also set, applications at EL0 run in the hypervisor regime and all of their interrupts go to EL2. The decode is combinational. A parameter adds one register stage on the outputs. That stage is enabled by default, which gives a latency of one cycle.

Top module: `vhost_mode_decoder`

## Requirements
- R1: `regimeSel` is 2 (EL3 regime) at level 3, 1 (EL2 regime) at level 2, and 0 (EL1&0 regime) at level 1. At level 0 it is 1 when host-extension and host-trap are both set, and 0 otherwise.
- R2: `twoRegion` and `asidEn` are both 1 in the EL1&0 regime and both 0 in the EL3 regime. In the EL2 regime both are equal to host-extension: with host-extension clear the regime is one region at the bottom of the address range with no identifiers.
- R3: Register class 0 (EL1-named) reaches the EL1 bank at levels 1 and 3, and at level 2 with host-extension clear. At level 2 with host-extension set it is redirected to the EL2 bank. At level 0 it is undefined.
- R4: Register class 1 (EL2-named) reaches the EL2 bank at levels 2 and 3 and is undefined at levels 0 and 1.
- R5: Register class 2 (EL12/EL02 alias) reaches the EL1 bank only at level 2 with host-extension set. Any other level, or host-extension clear, makes it undefined.
- R6: Register class 3 (other) always reaches the common bank and is never undefined.
- R7: `bankSel` is one-hot or zero, with bit 0 for the EL1 bank, bit 1 for the EL2 bank and bit 2 for the common bank. When `undefAcc` is 1, `bankSel` is 0.
- R8: With no override in force, a class whose routing bit is 0 targets level 1, and a class whose routing bit is 1 targets level 2. Classes are bit 0 IRQ, bit 1 FIQ and bit 2 SError. Class c has its target in `intTgt[2c+1:2c]`.
- R9: At level 0 with host-trap set, every class targets level 2, whatever its routing bit holds.
- R10: A set monitor override bit sends its class to level 3. This takes priority over all other routing.
- R11: A target is never below the current level. At level 3 every class targets level 3, and at level 2 the targets are never level 1.
- R12: With the output stage enabled, outputs follow the inputs one clock later, and all outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| curLevel | input | 2 | Current exception level, 0 to 3 |
| hostExtEn | input | 1 | Host-extension enable |
| hostTrapGen | input | 1 | Host-trap bit (EL0 belongs to the host) |
| routeBits | input | 3 | Per-class routing to EL2 (IRQ, FIQ, SError) |
| monRoute | input | 3 | Per-class secure-monitor routing to EL3 |
| regClass | input | 2 | Register access class: 0 EL1-named, 1 EL2-named, 2 alias, 3 other |
| regimeSel | output | 2 | Translation regime: 0 EL1&0, 1 EL2, 2 EL3 |
| twoRegion | output | 1 | Regime has both lower and upper regions |
| asidEn | output | 1 | Regime uses address space identifiers |
| bankSel | output | 3 | One-hot bank: bit0 EL1, bit1 EL2, bit2 common |
| undefAcc | output | 1 | Register access is undefined |
| intTgt | output | 6 | Target level per interrupt class, 2 bits each |

## Verification
The assertions check on every cycle that the bank select is one-hot or zero and is cleared on an undefined access. They also check that a monitor override always wins, that host-trap at EL0 forces EL2 routing, that the hypervisor regime is flat when host-extension is clear, that the alias reaches the EL1 bank at EL2, and that level 3 keeps all targets at 3. Only the bench's scenarios show the full decode tables and the typical guest and host settings. They also show the one-cycle latency and the reset values. The bench sweeps all 4096 input combinations against an independent reference.

// File: rtl/vhd_pkg.sv
package vhd_pkg;

  localparam logic [1:0] LVL_EL0 = 2'd0;
  localparam logic [1:0] LVL_EL1 = 2'd1;
  localparam logic [1:0] LVL_EL2 = 2'd2;
  localparam logic [1:0] LVL_EL3 = 2'd3;

  localparam logic [1:0] CLS_EL1N  = 2'd0;
  localparam logic [1:0] CLS_EL2N  = 2'd1;
  localparam logic [1:0] CLS_ALIAS = 2'd2;
  localparam logic [1:0] CLS_OTHER = 2'd3;

  localparam logic [1:0] RGM_EL10 = 2'd0;
  localparam logic [1:0] RGM_EL2  = 2'd1;
  localparam logic [1:0] RGM_EL3  = 2'd2;

  localparam int BANK_W   = 3;
  localparam int BANK_EL1 = 0;
  localparam int BANK_EL2 = 1;
  localparam int BANK_COM = 2;

  typedef struct packed {
    logic useEl3Regime;
    logic useEl2Regime;
    logic hostLayout;
    logic hitEl1Bank;
    logic hitEl2Bank;
    logic hitComBank;
    logic undefAcc;
    logic forceEl2Route;
  } ctrlStrobe_t;

endpackage

// File: rtl/vhd_ctrl.sv
module vhd_ctrl
  import vhd_pkg::*;
(
  input  logic [1:0]  curLevel,
  input  logic        hostExtEn,
  input  logic        hostTrapGen,
  input  logic [1:0]  regClass,
  output ctrlStrobe_t strb
);

  logic isEl0, isEl1, isEl2, isEl3;
  logic redirect;

  assign isEl0 = (curLevel == LVL_EL0);
  assign isEl1 = (curLevel == LVL_EL1);
  assign isEl2 = (curLevel == LVL_EL2);
  assign isEl3 = (curLevel == LVL_EL3);

  // EL2 with host extension: EL1-named names move to EL2, alias opens
  assign redirect = isEl2 & hostExtEn;

  always_comb begin
    strb = '0;
    strb.useEl3Regime  = isEl3;
    strb.useEl2Regime  = isEl2 | (isEl0 & hostExtEn & hostTrapGen);
    strb.hostLayout    = hostExtEn;
    strb.forceEl2Route = isEl0 & hostTrapGen;
    case (regClass)
      CLS_EL1N: begin
        if (isEl0)         strb.undefAcc   = 1'b1;
        else if (redirect) strb.hitEl2Bank = 1'b1;
        else               strb.hitEl1Bank = 1'b1;
      end
      CLS_EL2N: begin
        if (isEl2 | isEl3) strb.hitEl2Bank = 1'b1;
        else               strb.undefAcc   = 1'b1;
      end
      CLS_ALIAS: begin
        if (redirect)      strb.hitEl1Bank = 1'b1;
        else               strb.undefAcc   = 1'b1;
      end
      default: strb.hitComBank = 1'b1;
    endcase
    if (isEl1) strb.forceEl2Route = 1'b0;
  end

endmodule

// File: rtl/vhd_datapath.sv
module vhd_datapath
  import vhd_pkg::*;
#(
  parameter int NUM_CLS = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int TGT_W  = 2 * NUM_CLS
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [1:0]         curLevel,
  input  logic [NUM_CLS-1:0] routeBits,
  input  logic [NUM_CLS-1:0] monRoute,
  output logic [1:0]         regimeSel,
  output logic               twoRegion,
  output logic               asidEn,
  output logic [BANK_W-1:0]  bankSel,
  output logic               undefAcc,
  output logic [TGT_W-1:0]   intTgt
);

  logic [1:0]        regimeNxt;
  logic              layoutNxt;
  logic [BANK_W-1:0] bankNxt;
  logic [TGT_W-1:0]  tgtNxt;

  always_comb begin
    if (strb.useEl3Regime) begin
      regimeNxt = RGM_EL3;
      layoutNxt = 1'b0;
    end else if (strb.useEl2Regime) begin
      regimeNxt = RGM_EL2;
      layoutNxt = strb.hostLayout;
    end else begin
      regimeNxt = RGM_EL10;
      layoutNxt = 1'b1;
    end
  end

  always_comb begin
    bankNxt           = '0;
    bankNxt[BANK_EL1] = strb.hitEl1Bank;
    bankNxt[BANK_EL2] = strb.hitEl2Bank;
    bankNxt[BANK_COM] = strb.hitComBank;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_route
    logic [1:0] rawTgt;
    always_comb begin
      if (monRoute[c])             rawTgt = LVL_EL3;
      else if (strb.forceEl2Route) rawTgt = LVL_EL2;
      else if (routeBits[c])       rawTgt = LVL_EL2;
      else                         rawTgt = LVL_EL1;
    end
    assign tgtNxt[2*c +: 2] = (rawTgt < curLevel) ? curLevel : rawTgt;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regimeSel <= '0;
        twoRegion <= 1'b0;
        asidEn    <= 1'b0;
        bankSel   <= '0;
        undefAcc  <= 1'b0;
        intTgt    <= '0;
      end else begin
        regimeSel <= regimeNxt;
        twoRegion <= layoutNxt;
        asidEn    <= layoutNxt;
        bankSel   <= bankNxt;
        undefAcc  <= strb.undefAcc;
        intTgt    <= tgtNxt;
      end
    end
  end else begin : g_comb
    assign regimeSel = regimeNxt;
    assign twoRegion = layoutNxt;
    assign asidEn    = layoutNxt;
    assign bankSel   = bankNxt;
    assign undefAcc  = strb.undefAcc;
    assign intTgt    = tgtNxt;
  end

endmodule

// File: rtl/vhost_mode_decoder.sv
module vhost_mode_decoder
  import vhd_pkg::*;
#(
  parameter int NUM_CLS = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             curLevel,
  input  logic                   hostExtEn,
  input  logic                   hostTrapGen,
  input  logic [NUM_CLS-1:0]     routeBits,
  input  logic [NUM_CLS-1:0]     monRoute,
  input  logic [1:0]             regClass,
  output logic [1:0]             regimeSel,
  output logic                   twoRegion,
  output logic                   asidEn,
  output logic [2:0]             bankSel,
  output logic                   undefAcc,
  output logic [2*NUM_CLS-1:0]   intTgt
);

  ctrlStrobe_t strb;

  vhd_ctrl u_ctrl (
    .curLevel    (curLevel),
    .hostExtEn   (hostExtEn),
    .hostTrapGen (hostTrapGen),
    .regClass    (regClass),
    .strb        (strb)
  );

  vhd_datapath #(
    .NUM_CLS (NUM_CLS),
    .REG_OUT (REG_OUT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .curLevel  (curLevel),
    .routeBits (routeBits),
    .monRoute  (monRoute),
    .regimeSel (regimeSel),
    .twoRegion (twoRegion),
    .asidEn    (asidEn),
    .bankSel   (bankSel),
    .undefAcc  (undefAcc),
    .intTgt    (intTgt)
  );

endmodule

// File: rtl/vhost_mode_decoder_chk.sv
module vhost_mode_decoder_chk #(
  parameter int NUM_CLS = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           curLevel,
  input logic                 hostExtEn,
  input logic                 hostTrapGen,
  input logic [NUM_CLS-1:0]   routeBits,
  input logic [NUM_CLS-1:0]   monRoute,
  input logic [1:0]           regClass,
  input logic [1:0]           regimeSel,
  input logic                 twoRegion,
  input logic                 asidEn,
  input logic [2:0]           bankSel,
  input logic                 undefAcc,
  input logic [2*NUM_CLS-1:0] intTgt
);

  logic [1:0]         pLevel;
  logic               pExt;
  logic               pTrap;
  logic [NUM_CLS-1:0] pMon;
  logic [1:0]         pClass;
  logic               pValid;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pLevel <= '0;
        pExt   <= 1'b0;
        pTrap  <= 1'b0;
        pMon   <= '0;
        pClass <= '0;
        pValid <= 1'b0;
      end else begin
        pLevel <= curLevel;
        pExt   <= hostExtEn;
        pTrap  <= hostTrapGen;
        pMon   <= monRoute;
        pClass <= regClass;
        pValid <= 1'b1;
      end
    end
  end else begin : g_pass
    assign pLevel = curLevel;
    assign pExt   = hostExtEn;
    assign pTrap  = hostTrapGen;
    assign pMon   = monRoute;
    assign pClass = regClass;
    assign pValid = 1'b1;
  end

  // R7
  bank_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankSel));

  // R7
  undef_nobank_chk: assert property (@(posedge clk) disable iff (!rstN)
    undefAcc |-> (bankSel == 3'b000));

  // R2
  flat_el2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && pLevel == 2'd2 && !pExt) |-> (!twoRegion && !asidEn));

  // R5
  alias_reach_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && pLevel == 2'd2 && pExt && pClass == 2'd2) |-> (bankSel == 3'b001 && !undefAcc));

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    // R10
    monitor_el3_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pValid && pMon[c]) |-> (intTgt[2*c +: 2] == 2'd3));

    // R9
    host_trap_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pValid && pLevel == 2'd0 && pTrap && !pMon[c]) |-> (intTgt[2*c +: 2] == 2'd2));

    // R11
    no_lower_target_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pValid && pLevel == 2'd3) |-> (intTgt[2*c +: 2] == 2'd3));
  end

endmodule

bind vhost_mode_decoder vhost_mode_decoder_chk #(
  .NUM_CLS (NUM_CLS),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .curLevel    (curLevel),
  .hostExtEn   (hostExtEn),
  .hostTrapGen (hostTrapGen),
  .routeBits   (routeBits),
  .monRoute    (monRoute),
  .regClass    (regClass),
  .regimeSel   (regimeSel),
  .twoRegion   (twoRegion),
  .asidEn      (asidEn),
  .bankSel     (bankSel),
  .undefAcc    (undefAcc),
  .intTgt      (intTgt)
);

// File: tb/vhost_mode_decoder_tb.sv
module vhost_mode_decoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] curLevel = '0;
  logic       hostExtEn = 1'b0;
  logic       hostTrapGen = 1'b0;
  logic [2:0] routeBits = '0;
  logic [2:0] monRoute = '0;
  logic [1:0] regClass = '0;
  logic [1:0] regimeSel;
  logic       twoRegion;
  logic       asidEn;
  logic [2:0] bankSel;
  logic       undefAcc;
  logic [5:0] intTgt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vhost_mode_decoder u_dut (
    .clk(clk), .rstN(rstN), .curLevel(curLevel), .hostExtEn(hostExtEn),
    .hostTrapGen(hostTrapGen), .routeBits(routeBits), .monRoute(monRoute),
    .regClass(regClass), .regimeSel(regimeSel), .twoRegion(twoRegion),
    .asidEn(asidEn), .bankSel(bankSel), .undefAcc(undefAcc), .intTgt(intTgt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (lvl=%0d ext=%0d trap=%0d rt=%b mon=%b cls=%0d)",
               req, act, exp, curLevel, hostExtEn, hostTrapGen, routeBits, monRoute, regClass);
    end
  endtask

  // drive, wait for the output register, sample 2 ns after the edge
  task automatic apply(input int lvl, input bit ext, input bit trap,
                       input logic [2:0] rt, input logic [2:0] mon, input int cls);
    curLevel = 2'(lvl); hostExtEn = ext; hostTrapGen = trap;
    routeBits = rt; monRoute = mon; regClass = 2'(cls);
    @(posedge clk); #2;
  endtask

  // independent reference of all requirements for the inputs now applied
  task automatic checkAll();
    int lvl; int cls; int expRgm; int expLay; int expBank; int expUndef;
    string bankReq;
    lvl = int'(curLevel); cls = int'(regClass);
    // R1
    if (lvl == 3) expRgm = 2;
    else if (lvl == 2) expRgm = 1;
    else if (lvl == 0 && hostExtEn && hostTrapGen) expRgm = 1;
    else expRgm = 0;
    chk("R1 regime", int'(regimeSel), expRgm);
    // R2
    expLay = (expRgm == 0) ? 1 : (expRgm == 2) ? 0 : int'(hostExtEn);
    chk("R2 twoRegion", int'(twoRegion), expLay);
    chk("R2 asidEn", int'(asidEn), expLay);
    expUndef = 0; expBank = 0;
    case (cls)
      0: begin
        bankReq = "R3 bank";
        if (lvl == 0) expUndef = 1;
        else if (lvl == 2 && hostExtEn) expBank = 2;
        else expBank = 1;
      end
      1: begin
        bankReq = "R4 bank";
        if (lvl >= 2) expBank = 2; else expUndef = 1;
      end
      2: begin
        bankReq = "R5 bank";
        if (lvl == 2 && hostExtEn) expBank = 1; else expUndef = 1;
      end
      default: begin
        bankReq = "R6 bank";
        expBank = 4;
      end
    endcase
    chk(bankReq, int'(bankSel), expBank);
    chk("R7 undefAcc", int'(undefAcc), expUndef);
    for (int c = 0; c < 3; c++) begin
      int raw; string rq;
      if (monRoute[c]) begin raw = 3; rq = "R10 target"; end
      else if (lvl == 0 && hostTrapGen) begin raw = 2; rq = "R9 target"; end
      else begin raw = routeBits[c] ? 2 : 1; rq = "R8 target"; end
      if (raw < lvl) begin raw = lvl; rq = "R11 target"; end
      chk(rq, int'(intTgt[2*c +: 2]), raw);
    end
  endtask

  task automatic t_reset();
    // R12 reset values
    chk("R12 reset regime", int'(regimeSel), 0);
    chk("R12 reset layout", int'({twoRegion, asidEn}), 0);
    chk("R12 reset bank", int'(bankSel), 0);
    chk("R12 reset undef", int'(undefAcc), 0);
    chk("R12 reset tgt", int'(intTgt), 0);
  endtask

  task automatic t_typical();
    // guest kernel: EL1, ext=1 trap=0, EL1-named -> EL1 bank, IRQ to EL2
    apply(1, 1, 0, 3'b001, 3'b000, 0);
    chk("R3 guest kernel bank", int'(bankSel), 1);
    chk("R8 guest kernel irq", int'(intTgt[1:0]), 2);
    chk("R8 guest kernel fiq", int'(intTgt[3:2]), 1);
    // guest application: EL0, EL1&0 regime
    apply(0, 1, 0, 3'b000, 3'b000, 3);
    chk("R1 guest app regime", int'(regimeSel), 0);
    // host kernel: EL2, ext=1 trap=1, EL1-named redirected
    apply(2, 1, 1, 3'b000, 3'b000, 0);
    chk("R3 host kernel redirect", int'(bankSel), 2);
    chk("R2 host kernel two region", int'(twoRegion), 1);
    // host application: EL0, host regime, all classes to EL2
    apply(0, 1, 1, 3'b000, 3'b000, 3);
    chk("R1 host app regime", int'(regimeSel), 1);
    chk("R9 host app routing", int'(intTgt), 6'b101010);
  endtask

  task automatic t_alias();
    apply(2, 1, 1, 3'b000, 3'b000, 2);
    chk("R5 alias at host EL2", int'(bankSel), 1);
    apply(2, 0, 0, 3'b000, 3'b000, 2);
    chk("R5 alias without ext undef", int'(undefAcc), 1);
    chk("R7 alias without ext no bank", int'(bankSel), 0);
  endtask

  task automatic t_monitor();
    apply(0, 1, 1, 3'b111, 3'b010, 1);
    chk("R10 monitor overrides host trap", int'(intTgt), 6'b101110);
    chk("R4 EL2-named at EL0 undef", int'(undefAcc), 1);
  endtask

  task automatic t_latency();
    apply(3, 0, 0, 3'b000, 3'b000, 3);
    curLevel = 2'd1; regClass = 2'd2;
    #3;
    // R12: change before the edge is not yet visible
    chk("R12 holds until edge", int'(regimeSel), 2);
    @(posedge clk); #2;
    chk("R12 updates after edge", int'(regimeSel), 0);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 4096; v++) begin
      apply(v & 3, v[2], v[3], 3'(v >> 4), 3'(v >> 7), (v >> 10) & 3);
      checkAll();
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rstN = 1'b1;
    t_typical();
    t_alias();
    t_monitor();
    t_latency();
    t_sweep();
    finishRun();
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    finishRun();
  end

endmodule